// File: doc/BRIEF.md
# Module Clock Gate Controller with Activity Monitors

This block holds the enable bits for a set of module clocks together with a bank of bus master-stop bits, all reached through a simple word-wide register bus. Each clock-enable register controls sixteen module clocks. Each enable bit drives a gate-enable output. A matching monitor bit follows the enable bit after a fixed, parameterised number of cycles. The monitor models the time a real gate needs to open or close. A clock is reported ready only when both its enable bit and its monitor bit are 1. Each master-stop register holds sixteen stop bits that fence a module off the interconnect.

Software never overwrites a whole register. The upper half-word of every write is a per-bit write-enable mask, and the lower half-word supplies the new values. Only bits whose mask bit is set change. Several drivers can therefore share one register without a read-modify-write. The expected use is ordered. To bring a module up, software sets its enable bit, waits for ready, and then releases its master stop. To take a module down, software sets the stop first and then clears the enable.

Top module: `modclk_gate_bank`

## Requirements
- R1: When reset is low at a clock edge, all enable bits, monitor bits, ready outputs and read data become 0, and all master-stop bits become 1.
- R2: A write to enable register k (byte address 0x600 + 4*k) changes enable bit i of that register to wdata[i] exactly when wdata[i+16] is 1. Other bits keep their value. The new value appears on `gate_en[16*k+i]` right after the write edge.
- R3: A write to master-stop register m, counted from m = 1 at byte address 0xD00 + 4*(m-1), changes stop bit i under the same per-bit mask rule. With wdata[i+16] = 1, a data bit of 0 releases the stop and a data bit of 1 sets it. The result appears on `mstop[16*(m-1)+i]` right after the write edge.
- R4: A write whose upper half-word is zero leaves every enable and stop bit unchanged.
- R5: A read issued at one edge returns its data on `bus_rdata` after that edge, for one cycle only. Bits 31:16 of read data are always 0. `bus_rdata` is 0 in every other cycle. An unmapped address reads as 0. An address only matches a register when its two low bits are 0.
- R6: Monitor bit i of register k, readable at byte address 0x680 + 4*k, equals the enable bit as it stood MON_DELAY edges earlier. It rises MON_DELAY edges after the enable is set and falls MON_DELAY edges after it is cleared. With the default of 4 cycles this is far inside a 10 µs limit.
- R7: `clk_ready` bit j is 1 exactly when enable bit j and its monitor bit are both 1.
- R8: Writes to a monitor address or to an unmapped address change no enable or stop bit. Cycles without a write leave all enable and stop bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data: [31:16] per-bit enable mask, [15:0] values |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| gate_en | output | 16*N_ON | Module clock gate enables |
| clk_ready | output | 16*N_ON | Enable and monitor both set |
| mstop | output | 16*N_STOP | Bus master-stop bits (1 = stopped) |

## Verification
Enable and stop bits change at the write edge itself, so their outputs are compared one time step after that edge. Read data is due after the edge that accepted the read and reflects the register state from before that edge. The monitor and `clk_ready` are due exactly MON_DELAY edges after the enable change. The bench checks one edge early and on the due edge to pin this down. A behavioural model in the bench keeps a history queue of enable values and applies the same due-cycle rules. The model is compared with every output after each edge.

// File: rtl/modclk_pkg.sv
// Shared widths, types and the masked half-word update rule used by every
// writable register of the module clock gate bank.
package modclk_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 32;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [WORD_W-1:0] word_t;

    // New register value: bits whose mask bit (upper half) is set take the
    // data value (lower half); all other bits keep the current value.
    function automatic half_t masked_merge(half_t cur, word_t wr);
        half_t mask;
        mask = wr[WORD_W-1:HALF_W];
        return (cur & ~mask) | (wr[HALF_W-1:0] & mask);
    endfunction
endpackage

// File: rtl/modclk_wen_reg.sv
// Sixteen-bit control register with per-bit write enables.
// Assumes: wr_en is already qualified by address decode and a bus write.
// The reset value is a parameter so one cell serves enables and stops.
module modclk_wen_reg
    import modclk_pkg::*;
#(
    parameter half_t RESET_VAL = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  word_t wdata,
    output half_t q
);
    // Masked update on a decoded write, reset value otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else if (wr_en) begin
            q <= masked_merge(q, wdata);
        end
    end
endmodule

// File: rtl/modclk_mon_pipe.sv
// Activity monitor model: delays a vector of gate enables by DEPTH edges,
// standing in for the open/close latency of real gating cells.
// Assumes: the delay is identical for rising and falling enables.
module modclk_mon_pipe #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] mon
);
    generate
        if (DEPTH == 0) begin : g_direct
            assign mon = din;
        end else begin : g_shift
            logic [WIDTH-1:0] stage_q [DEPTH];

            // Shift the enable vector one stage per edge, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int s = 0; s < DEPTH; s++) begin
                        stage_q[s] <= '0;
                    end
                end else begin
                    stage_q[0] <= din;
                    for (int s = 1; s < DEPTH; s++) begin
                        stage_q[s] <= stage_q[s-1];
                    end
                end
            end

            assign mon = stage_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/modclk_addr_dec.sv
// Address decoder for the three register groups: enable, monitor and stop.
// Assumes: full-address match, so a misaligned address hits nothing.
module modclk_addr_dec #(
    parameter int ADDR_W    = 12,
    parameter int N_ON      = 4,
    parameter int N_STOP    = 2,
    parameter int ON_BASE   = 'h600,
    parameter int MON_BASE  = 'h680,
    parameter int STOP_BASE = 'hD00
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_ON-1:0]   on_hit,
    output logic [N_ON-1:0]   mon_hit,
    output logic [N_STOP-1:0] stop_hit
);
    localparam int STRIDE = 4;

    genvar k;
    generate
        for (k = 0; k < N_ON; k++) begin : g_on
            assign on_hit[k]  = (addr == ADDR_W'(ON_BASE  + STRIDE * k));
            assign mon_hit[k] = (addr == ADDR_W'(MON_BASE + STRIDE * k));
        end
        for (k = 0; k < N_STOP; k++) begin : g_stop
            assign stop_hit[k] = (addr == ADDR_W'(STOP_BASE + STRIDE * k));
        end
    endgenerate
endmodule

// File: rtl/modclk_gate_bank.sv
// Module clock gate bank: enable registers with delayed activity monitors
// and a bank of bus master-stop registers behind one register port.
// Assumes: single-cycle bus requests; read data is registered and valid
// for one cycle after the read; writes take effect at the request edge.
module modclk_gate_bank
    import modclk_pkg::*;
#(
    parameter int N_ON      = 4,
    parameter int N_STOP    = 2,
    parameter int MON_DELAY = 4,
    parameter int ADDR_W    = 12,
    parameter int ON_BASE   = 'h600,
    parameter int MON_BASE  = 'h680,
    parameter int STOP_BASE = 'hD00
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic [N_ON*HALF_W-1:0]   gate_en,
    output logic [N_ON*HALF_W-1:0]   clk_ready,
    output logic [N_STOP*HALF_W-1:0] mstop
);
    localparam int ON_BITS   = N_ON * HALF_W;
    localparam int STOP_BITS = N_STOP * HALF_W;

    logic [N_ON-1:0]      on_hit;
    logic [N_ON-1:0]      mon_hit;
    logic [N_STOP-1:0]    stop_hit;
    logic [ON_BITS-1:0]   on_q;
    logic [ON_BITS-1:0]   mon_q;
    logic [STOP_BITS-1:0] stop_q;
    logic                 wr_strobe;
    logic                 rd_strobe;
    half_t                rd_half;

    assign wr_strobe = bus_sel & bus_wr;
    assign rd_strobe = bus_sel & ~bus_wr;

    modclk_addr_dec #(
        .ADDR_W   (ADDR_W),
        .N_ON     (N_ON),
        .N_STOP   (N_STOP),
        .ON_BASE  (ON_BASE),
        .MON_BASE (MON_BASE),
        .STOP_BASE(STOP_BASE)
    ) u_dec (
        .addr    (bus_addr),
        .on_hit  (on_hit),
        .mon_hit (mon_hit),
        .stop_hit(stop_hit)
    );

    genvar k;
    generate
        for (k = 0; k < N_ON; k++) begin : g_on_reg
            modclk_wen_reg #(.RESET_VAL('0)) u_on (
                .clk  (clk),
                .rst_n(rst_n),
                .wr_en(wr_strobe & on_hit[k]),
                .wdata(bus_wdata),
                .q    (on_q[k*HALF_W +: HALF_W])
            );
        end
        for (k = 0; k < N_STOP; k++) begin : g_stop_reg
            modclk_wen_reg #(.RESET_VAL('1)) u_stop (
                .clk  (clk),
                .rst_n(rst_n),
                .wr_en(wr_strobe & stop_hit[k]),
                .wdata(bus_wdata),
                .q    (stop_q[k*HALF_W +: HALF_W])
            );
        end
    endgenerate

    modclk_mon_pipe #(
        .WIDTH(ON_BITS),
        .DEPTH(MON_DELAY)
    ) u_mon (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (on_q),
        .mon  (mon_q)
    );

    // Read multiplexer: OR of the one register the address selects.
    always_comb begin
        rd_half = '0;
        for (int r = 0; r < N_ON; r++) begin
            if (on_hit[r])  rd_half = rd_half | on_q[r*HALF_W +: HALF_W];
            if (mon_hit[r]) rd_half = rd_half | mon_q[r*HALF_W +: HALF_W];
        end
        for (int r = 0; r < N_STOP; r++) begin
            if (stop_hit[r]) rd_half = rd_half | stop_q[r*HALF_W +: HALF_W];
        end
    end

    // Registered read data, zero outside the cycle after a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_strobe) begin
            bus_rdata <= {{(WORD_W-HALF_W){1'b0}}, rd_half};
        end else begin
            bus_rdata <= '0;
        end
    end

    assign gate_en   = on_q;
    assign mstop     = stop_q;
    assign clk_ready = on_q & mon_q;
endmodule

// File: rtl/modclk_gate_bank_chk.sv
// Property checker for modclk_gate_bank, bound to every instance.
// Tracks how long the enable vector has been steady to check monitor lag.
module modclk_gate_bank_chk #(
    parameter int N_ON      = 4,
    parameter int N_STOP    = 2,
    parameter int MON_DELAY = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [N_ON*16-1:0]   gate_en,
    input logic [N_ON*16-1:0]   clk_ready,
    input logic [N_ON*16-1:0]   mon_bits,
    input logic [N_STOP*16-1:0] mstop
);
    localparam int CW = $clog2(MON_DELAY + 2) + 1;

    logic [N_ON*16-1:0] prev_on;
    logic [CW-1:0]      steady_cnt;
    logic               on_changed;
    logic               settled;

    assign on_changed = (gate_en != prev_on);
    assign settled    = !on_changed && (steady_cnt >= CW'(MON_DELAY));

    // Count edges since the enable vector last changed, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_on    <= '0;
            steady_cnt <= '0;
        end else if (on_changed) begin
            prev_on    <= gate_en;
            steady_cnt <= '0;
        end else if (steady_cnt < CW'(MON_DELAY)) begin
            steady_cnt <= steady_cnt + 1'b1;
        end
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (gate_en == '0) && (mstop == '1) && (clk_ready == '0));

    p_no_mask_no_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_wdata[31:16] == 16'h0)
        |=> $stable(gate_en) && $stable(mstop));

    p_rdata_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:16] == 16'h0);

    p_idle_rdata_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> bus_rdata == 32'h0);

    p_monitor_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        settled |-> mon_bits == gate_en);

    p_ready_settled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        settled |-> clk_ready == gate_en);

    p_no_write_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> $stable(gate_en) && $stable(mstop));
endmodule

bind modclk_gate_bank modclk_gate_bank_chk #(
    .N_ON     (N_ON),
    .N_STOP   (N_STOP),
    .MON_DELAY(MON_DELAY)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .gate_en  (gate_en),
    .clk_ready(clk_ready),
    .mon_bits (mon_q),
    .mstop    (mstop)
);

// File: tb/modclk_gate_bank_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared after every clock edge,
// plus directed checks with expected values written from the requirements.
module modclk_gate_bank_bench;
    localparam int N_ON   = 4;
    localparam int N_STOP = 2;
    localparam int D      = 4;
    localparam int ONB    = N_ON * 16;
    localparam int STB    = N_STOP * 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [ONB-1:0]  gate_en;
    logic [ONB-1:0]  clk_ready;
    logic [STB-1:0]  mstop;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model state
    logic [ONB-1:0] m_on;
    logic [STB-1:0] m_stop;
    logic [ONB-1:0] m_mon;
    logic [31:0]    m_rd;
    logic [ONB-1:0] hist[$];

    always #10 clk = ~clk;  // 50 MHz

    modclk_gate_bank #(.N_ON(N_ON), .N_STOP(N_STOP), .MON_DELAY(D)) u_modclk_gate_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gate_en(gate_en), .clk_ready(clk_ready), .mstop(mstop)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] apply_mask(logic [15:0] cur, logic [31:0] d);
        logic [15:0] r = cur;
        for (int i = 0; i < 16; i++) if (d[i+16]) r[i] = d[i];
        return r;
    endfunction

    function automatic logic [15:0] model_read(logic [11:0] a);
        logic [15:0] r = '0;
        for (int k = 0; k < N_ON; k++) begin
            if (a == 12'h600 + 12'(4*k)) r = m_on[k*16 +: 16];
            if (a == 12'h680 + 12'(4*k)) r = m_mon[k*16 +: 16];
        end
        for (int m = 1; m <= N_STOP; m++)
            if (a == 12'hD00 + 12'(4*(m-1))) r = m_stop[(m-1)*16 +: 16];
        return r;
    endfunction

    task automatic model_reset();
        m_on = '0; m_stop = '1; m_mon = '0; m_rd = '0;
        hist.delete();
    endtask

    // Model one edge with the given bus inputs.
    task automatic model_step(input logic s, input logic w, input logic [11:0] a, input logic [31:0] d);
        m_rd = (s && !w) ? {16'h0, model_read(a)} : 32'h0;
        if (s && w) begin
            for (int k = 0; k < N_ON; k++)
                if (a == 12'h600 + 12'(4*k)) m_on[k*16 +: 16] = apply_mask(m_on[k*16 +: 16], d);
            for (int m = 1; m <= N_STOP; m++)
                if (a == 12'hD00 + 12'(4*(m-1)))
                    m_stop[(m-1)*16 +: 16] = apply_mask(m_stop[(m-1)*16 +: 16], d);
        end
        hist.push_back(m_on);
        if (hist.size() > D + 1) void'(hist.pop_front());
        m_mon = (hist.size() > D) ? hist[hist.size()-1-D] : '0;
    endtask

    task automatic compare_all();
        chk("R2 gate_en vs model", 64'(gate_en), 64'(m_on));
        chk("R3 mstop vs model", 64'(mstop), 64'(m_stop));
        chk("R6/R7 clk_ready vs model", 64'(clk_ready), 64'(m_on & m_mon));
        chk("R5 bus_rdata vs model", 64'(bus_rdata), 64'(m_rd));
    endtask

    task automatic cyc(input logic s, input logic w, input logic [11:0] a, input logic [31:0] d);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        model_step(s, w, a, d);
        compare_all();
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b1, a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 12'h0, 32'h0);
    endtask

    task automatic rd_expect(input string tag, input logic [11:0] a, input logic [31:0] exp);
        cyc(1'b1, 1'b0, a, 32'h0);
        chk(tag, 64'(bus_rdata), 64'(exp));
    endtask

    initial begin
        model_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 gate_en after reset", 64'(gate_en), 64'h0);
        chk("R1 mstop after reset", 64'(mstop), 64'(32'hFFFF_FFFF));
        chk("R1 clk_ready after reset", 64'(clk_ready), 64'h0);
        chk("R1 rdata after reset", 64'(bus_rdata), 64'h0);
        rst_n = 1'b1;
        idle(2);

        // R2: masked write on enable register 0
        wr(12'h600, 32'h00FF_00A5);
        chk("R2 enable reg0 low byte", 64'(gate_en[15:0]), 64'h00A5);
        // R6: rise exactly D edges after the write edge
        idle(D - 1);
        chk("R6 monitor not yet risen", 64'(clk_ready[15:0]), 64'h0);
        idle(1);
        chk("R6 monitor risen on due edge", 64'(clk_ready[15:0]), 64'h00A5);
        rd_expect("R6 monitor register readback", 12'h680, 32'h0000_00A5);

        // R2: partial mask keeps unmasked bits
        wr(12'h600, 32'h0081_FF00);
        rd_expect("R2 partial mask readback", 12'h600, 32'h0000_0024);

        // R4: zero mask has no effect
        wr(12'h600, 32'h0000_FFFF);
        rd_expect("R4 zero mask no change", 12'h600, 32'h0000_0024);

        // R3: master-stop m=1 release bits 3:0, then set bit 2 again
        wr(12'hD00, 32'h000F_0000);
        chk("R3 stop released", 64'(mstop[15:0]), 64'hFFF0);
        wr(12'hD00, 32'h0004_0004);
        rd_expect("R3 stop bit set again", 12'hD00, 32'h0000_FFF4);
        // R3: last stop register m=2
        wr(12'hD04, 32'h8000_0000);
        chk("R3 stop reg 2 bit 15", 64'(mstop[31:16]), 64'h7FFF);

        // R8: monitor and unmapped writes change nothing
        wr(12'h680, 32'hFFFF_0000);
        wr(12'h7F0, 32'hFFFF_FFFF);
        wr(12'h602, 32'hFFFF_FFFF);
        chk("R8 gate_en unchanged", 64'(gate_en), 64'h0000_0000_0000_0024);
        chk("R8 mstop unchanged", 64'(mstop), 64'h7FFF_FFF4);
        // R5: unmapped and misaligned reads return zero
        rd_expect("R5 unmapped read", 12'h7F0, 32'h0);
        rd_expect("R5 misaligned read", 12'h602, 32'h0);
        idle(1);
        chk("R5 rdata zero after read", 64'(bus_rdata), 64'h0);

        // Enable sequence on last register k=3, then release its stop
        wr(12'h60C, 32'h8000_8000);
        chk("R2 enable reg3 bit 15", 64'(gate_en[63:48]), 64'h8000);
        idle(D);
        chk("R7 ready reg3 bit 15", 64'(clk_ready[63:48]), 64'h8000);
        wr(12'hD04, 32'h0001_0000);

        // R6: fall D edges after clear
        wr(12'hD04, 32'h0001_0001);
        wr(12'h60C, 32'h8000_0000);
        chk("R7 ready drops with enable", 64'(clk_ready[63:48]), 64'h0);
        idle(D - 1);
        rd_expect("R6 monitor still high before due", 12'h68C, 32'h0000_8000);
        rd_expect("R6 monitor low after due", 12'h68C, 32'h0);

        // Mixed traffic compared against the model every edge
        for (int n = 0; n < 600; n++) begin
            logic [11:0] a;
            logic [31:0] d;
            logic s, w;
            case ($urandom % 12)
                0, 1, 2, 3: a = 12'h600 + 12'(4 * ($urandom % N_ON));
                4, 5:       a = 12'h680 + 12'(4 * ($urandom % N_ON));
                6, 7, 8:    a = 12'hD00 + 12'(4 * ($urandom % N_STOP));
                9:          a = 12'h7F0;
                10:         a = 12'h601;
                default:    a = 12'hD08;
            endcase
            d = $urandom;
            s = ($urandom % 4) != 0;
            w = ($urandom % 2) == 0;
            cyc(s, w, a, d);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule